// File: doc/BRIEF.md
# Presence-Bit Deferred-Read Memory

This block is a write-once data store in which every location carries a presence bit. The bit shows whether the location has been filled. When a read targets a filled location, the block answers it at once with the stored word and the requester's tag. When a read targets an empty location, the block does not reject it. The request, with its address and tag, waits in a small deferred-request queue. The requester never stalls on the data.

When a write later fills a location, the block stores the word and sets the presence bit. It then answers every waiting read for that address from the queue, one response per cycle, oldest first. Each response carries the tag the reader supplied. If a write targets a location that is already filled, the block refuses it and pulses an error flag. A clear input empties the whole store and drops every waiting request in a single cycle.

All responses leave through one registered port. While queued responses are draining, new reads are held off so that no fresh read can overtake a queued one.

Top module: `pbm_deferred_mem`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, every location reads as empty, the queue holds no entries and `rsp_valid` is low. While `clr` is high, `rd_ready` is low and any read or write presented in that cycle has no effect.
- R2: A write to an empty location stores `wr_data` and marks the location present. `wr_err` stays low in the following cycle.
- R3: A write to a location that is already present leaves the stored word unchanged. `wr_err` is high for exactly the one cycle after that write.
- R4: A read of a present location that is accepted on a clock edge drives `rsp_valid` high from that same edge, with `rsp_tag` equal to the read's tag and `rsp_data` equal to the stored word.
- R5: A read of an empty location is accepted when the queue has room. It produces no response until its location is written.
- R6: The write that fills a location releases every queued read for that address. The first response appears one cycle later than a hit would, and the following responses come one per cycle on consecutive cycles.
- R7: Released reads are answered in the order they were accepted, each carrying its own tag. Entries for other addresses stay queued.
- R8: When the queue holds DEPTH entries, `rd_ready` is low for reads of empty locations. Reads of present locations are still accepted.
- R9: While any released entry is waiting to be answered, `rd_ready` is low for every read.
- R10: A read and a write of the same empty location in the same cycle queue the read, and that same write releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empty all locations and drop queued reads |
| rd_valid | input | 1 | Read request present |
| rd_addr | input | ADDR_W | Read address |
| rd_tag | input | TAG_W | Requester tag returned with the data |
| rd_ready | output | 1 | Read request accepted on this edge |
| wr_valid | input | 1 | Write request present (always taken) |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_err | output | 1 | Previous write hit an already-present location |
| rsp_valid | output | 1 | Response present |
| rsp_tag | output | TAG_W | Tag of the answered read |
| rsp_data | output | DATA_W | Data of the answered read |

## Verification
The bench builds the block with its defaults: 16 locations of 16 bits, 4-bit tags and an 8-entry queue. With these sizes, filling the queue takes only eight reads. That puts the full-queue back-pressure case, and the case where a hit is still accepted while the queue is full, within reach of short directed runs. Every tag can be distinct, so one failed run shows both release order and tag preservation. There are also runs with queued reads spread across several addresses, and runs where a read and a write meet on the same address in the same cycle.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  // Which path feeds the response register this cycle
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_HIT   = 2'd1,
    SRC_DRAIN = 2'd2
  } rsp_src_e;
endpackage

// File: rtl/pbm_store.sv
module pbm_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int NLOC = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [NLOC];

  // Single write port, registered read: block-RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pbm_presence.sv
module pbm_presence #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_full,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_full
);
  localparam int NLOC = 1 << ADDR_W;

  // Flops, not RAM: clear must empty every location in one cycle
  logic [NLOC-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst || clr) bits <= '0;
    else if (set_en) bits[set_addr] <= 1'b1;
  end

  assign rd_full = bits[rd_addr];
  assign wr_full = bits[wr_addr];

  // R2: a present location stays present until clear or reset
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && !$past(rst)) |-> ((bits & $past(bits)) == $past(bits)));
endmodule

// File: rtl/pbm_defer_queue.sv
module pbm_defer_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 4,
  parameter int TAG_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic                      push,
  input  logic [ADDR_W-1:0]         push_addr,
  input  logic [TAG_W-1:0]          push_tag,
  input  logic                      rel_en,
  input  logic [ADDR_W-1:0]         rel_addr,
  input  logic                      pop,
  output logic                      full,
  output logic                      any_ready,
  output logic [ADDR_W-1:0]         head_addr,
  output logic [TAG_W-1:0]          head_tag,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  // Entries stay packed from slot 0 (oldest) upward
  logic [DEPTH-1:0]  vld, rdy, n_vld, n_rdy;
  logic [ADDR_W-1:0] qa [DEPTH];
  logic [ADDR_W-1:0] n_qa [DEPTH];
  logic [TAG_W-1:0]  qt [DEPTH];
  logic [TAG_W-1:0]  n_qt [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  sel;

  // Oldest released entry
  always_comb begin
    any_ready = 1'b0;
    sel       = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (vld[i] && rdy[i]) begin
        any_ready = 1'b1;
        sel       = IDX_W'(i);
      end
    end
  end

  assign head_addr = qa[sel];
  assign head_tag  = qt[sel];
  assign full      = (cnt == CNT_W'(DEPTH));
  assign count     = cnt;

  always_comb begin
    n_vld = vld;
    n_rdy = rdy;
    n_qa  = qa;
    n_qt  = qt;
    if (pop) begin
      for (int i = 0; i < DEPTH-1; i++) begin
        if (IDX_W'(i) >= sel) begin
          n_vld[i] = vld[i+1];
          n_rdy[i] = rdy[i+1];
          n_qa[i]  = qa[i+1];
          n_qt[i]  = qt[i+1];
        end
      end
      n_vld[DEPTH-1] = 1'b0;
      n_rdy[DEPTH-1] = 1'b0;
    end
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == cnt) begin
          n_vld[i] = 1'b1;
          n_rdy[i] = 1'b0;
          n_qa[i]  = push_addr;
          n_qt[i]  = push_tag;
        end
      end
    end
    // Release after insertion so a same-cycle entry is caught too
    if (rel_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (n_vld[i] && (n_qa[i] == rel_addr)) n_rdy[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
      rdy <= '0;
      cnt <= '0;
    end else begin
      vld <= n_vld;
      rdy <= n_rdy;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    qa <= n_qa;
    qt <= n_qt;
  end

  a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);
  a_r9_no_push_pop: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/pbm_deferred_mem.sv
module pbm_deferred_mem
  import pbm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_ready,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_err,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic              pres_rd, pres_wr;
  logic              q_full, q_any;
  logic [ADDR_W-1:0] q_head_addr;
  logic [TAG_W-1:0]  q_head_tag;
  logic [CNT_W-1:0]  q_cnt;
  logic              rd_fire, wr_ok, wr_bad, push, pop;
  logic [ADDR_W-1:0] ram_raddr;
  rsp_src_e          src;

  assign rd_ready = !clr && !q_any && (pres_rd || !q_full);
  assign rd_fire  = rd_valid && rd_ready;
  assign wr_ok    = wr_valid && !clr && !pres_wr;
  assign wr_bad   = wr_valid && !clr && pres_wr;
  assign push     = rd_fire && !pres_rd;
  assign pop      = q_any && !clr;

  always_comb begin
    if (pop)                     src = SRC_DRAIN;
    else if (rd_fire && pres_rd) src = SRC_HIT;
    else                         src = SRC_NONE;
  end

  assign ram_raddr = (src == SRC_DRAIN) ? q_head_addr : rd_addr;

  pbm_presence #(.ADDR_W(ADDR_W)) u_presence (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .set_en   (wr_ok),
    .set_addr (wr_addr),
    .rd_addr  (rd_addr),
    .rd_full  (pres_rd),
    .wr_addr  (wr_addr),
    .wr_full  (pres_wr)
  );

  pbm_defer_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .flush     (clr),
    .push      (push),
    .push_addr (rd_addr),
    .push_tag  (rd_tag),
    .rel_en    (wr_ok),
    .rel_addr  (wr_addr),
    .pop       (pop),
    .full      (q_full),
    .any_ready (q_any),
    .head_addr (q_head_addr),
    .head_tag  (q_head_tag),
    .count     (q_cnt)
  );

  pbm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (ram_raddr),
    .rdata (rsp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      wr_err    <= 1'b0;
    end else begin
      rsp_valid <= (src != SRC_NONE);
      rsp_tag   <= (src == SRC_DRAIN) ? q_head_tag : rd_tag;
      wr_err    <= wr_bad;
    end
  end

  a_r9_hold_reads: assert property (@(posedge clk) disable iff (rst)
    q_any |-> !rd_ready);
  a_r1_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q_cnt == '0 && !rsp_valid));
  a_r4_hit_rsp: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && pres_rd) |=> (rsp_valid && rsp_tag == $past(rd_tag)));
  a_r3_reject_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !clr && pres_wr) |=> wr_err);
endmodule

// File: tb/pbm_deferred_mem_bench.sv
module pbm_deferred_mem_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int TAG_W  = 4;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rst, clr;
  logic              rd_valid, rd_ready;
  logic [ADDR_W-1:0] rd_addr;
  logic [TAG_W-1:0]  rd_tag;
  logic              wr_valid, wr_err;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              rsp_valid;
  logic [TAG_W-1:0]  rsp_tag;
  logic [DATA_W-1:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbm_deferred_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH))
  u_pbm_deferred_mem (
    .clk(clk), .rst(rst), .clr(clr),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_tag(rd_tag), .rd_ready(rd_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [TAG_W-1:0] t);
    rd_valid = 1'b1; rd_addr = a; rd_tag = t;
    #1;
    while (!rd_ready) tick();
    tick();
    rd_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
    chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " rsp_tag"}, 32'(rsp_tag), 32'(t));
    chk({req, " rsp_data"}, 32'(rsp_data), 32'(d));
  endtask

  task automatic t_reset();
    rd_valid = 0; rd_addr = '0; rd_tag = '0;
    wr_valid = 0; wr_addr = '0; wr_data = '0; clr = 0;
    rst = 1;
    repeat (3) tick();
    rst = 0;
    tick();
    chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 reset wr_err", 32'(wr_err), 32'd0);
    chk("R1 reset rd_ready", 32'(rd_ready), 32'd1);
  endtask

  task automatic t_write_hit();
    do_write(4'd3, 16'hBEEF);
    chk("R2 first write no error", 32'(wr_err), 32'd0);
    do_read(4'd3, 4'd5);
    expect_rsp("R4 hit", 4'd5, 16'hBEEF);
    tick();
    chk("R4 single response", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_double_write();
    do_write(4'd3, 16'h1111);
    chk("R3 wr_err raised", 32'(wr_err), 32'd1);
    tick();
    chk("R3 wr_err one cycle", 32'(wr_err), 32'd0);
    do_read(4'd3, 4'd6);
    expect_rsp("R3 data kept", 4'd6, 16'hBEEF);
    tick();
  endtask

  task automatic t_deferred();
    do_read(4'd7, 4'd1);
    chk("R5 miss no rsp", 32'(rsp_valid), 32'd0);
    do_read(4'd7, 4'd2);
    chk("R5 miss no rsp 2", 32'(rsp_valid), 32'd0);
    tick();
    chk("R5 still waiting", 32'(rsp_valid), 32'd0);
    do_write(4'd7, 16'h7777);
    chk("R6 no rsp on write edge", 32'(rsp_valid), 32'd0);
    rd_valid = 1'b1; rd_addr = 4'd3; rd_tag = 4'd9;
    #1;
    chk("R9 reads held during drain", 32'(rd_ready), 32'd0);
    rd_valid = 1'b0;
    tick();
    expect_rsp("R6 first release", 4'd1, 16'h7777);
    tick();
    expect_rsp("R6 second release", 4'd2, 16'h7777);
    tick();
    chk("R6 drain ends", 32'(rsp_valid), 32'd0);
    chk("R9 reads resume", 32'(rd_ready), 32'd1);
  endtask

  task automatic t_order();
    do_read(4'd8, 4'd3);
    do_read(4'd9, 4'd4);
    do_read(4'd8, 4'd5);
    do_write(4'd9, 16'h9999);
    tick();
    expect_rsp("R7 other addr first", 4'd4, 16'h9999);
    tick();
    chk("R7 addr 8 stays queued", 32'(rsp_valid), 32'd0);
    do_write(4'd8, 16'h8888);
    tick();
    expect_rsp("R7 oldest first", 4'd3, 16'h8888);
    tick();
    expect_rsp("R7 next oldest", 4'd5, 16'h8888);
    tick();
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) do_read(4'd12, TAG_W'(i));
    rd_valid = 1'b1; rd_addr = 4'd13; rd_tag = 4'd15;
    #1;
    chk("R8 miss blocked when full", 32'(rd_ready), 32'd0);
    rd_addr = 4'd3;
    #1;
    chk("R8 hit allowed when full", 32'(rd_ready), 32'd1);
    tick();
    rd_valid = 1'b0;
    expect_rsp("R8 hit while full", 4'd15, 16'hBEEF);
    do_write(4'd12, 16'hC0DE);
    for (int i = 0; i < DEPTH; i++) begin
      tick();
      expect_rsp("R6 full drain", TAG_W'(i), 16'hC0DE);
    end
    tick();
    chk("R6 full drain ends", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_same_cycle();
    rd_valid = 1'b1; rd_addr = 4'd14; rd_tag = 4'd6;
    wr_valid = 1'b1; wr_addr = 4'd14; wr_data = 16'h1414;
    #1;
    chk("R10 read accepted", 32'(rd_ready), 32'd1);
    tick();
    rd_valid = 1'b0; wr_valid = 1'b0;
    chk("R10 no rsp on edge", 32'(rsp_valid), 32'd0);
    tick();
    expect_rsp("R10 released by same write", 4'd6, 16'h1414);
    tick();
  endtask

  task automatic t_clear();
    do_read(4'd15, 4'd1);
    clr = 1'b1;
    rd_valid = 1'b1; rd_addr = 4'd3; rd_tag = 4'd7;
    #1;
    chk("R1 rd_ready low in clear", 32'(rd_ready), 32'd0);
    tick();
    clr = 1'b0; rd_valid = 1'b0;
    chk("R1 no rsp after clear", 32'(rsp_valid), 32'd0);
    do_write(4'd15, 16'h0005);
    chk("R1 write after clear ok", 32'(wr_err), 32'd0);
    tick();
    chk("R1 queue flushed", 32'(rsp_valid), 32'd0);
    tick();
    chk("R1 queue flushed 2", 32'(rsp_valid), 32'd0);
    do_read(4'd3, 4'd2);
    chk("R1 location emptied", 32'(rsp_valid), 32'd0);
    do_write(4'd3, 16'hAAAA);
    chk("R1 rewrite allowed", 32'(wr_err), 32'd0);
    tick();
    expect_rsp("R1 refill answers", 4'd2, 16'hAAAA);
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_write_hit();
    t_double_write();
    t_deferred();
    t_order();
    t_full();
    t_same_cycle();
    t_clear();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule